// File: doc/BRIEF.md
# Dual-Rail Handshake Register Stage

This block is one register stage of a clockless, dual-rail pipeline in which data and spacer wavefronts alternate. It carries `GROUPS` logical bits. Each bit travels on a pair of rails: a true rail and a false rail. At most one rail of a pair is high, and a pair with both rails low is the spacer value, called NULL.

Every output rail is a two-input hysteresis gate. One input is the incoming rail and the other is the request arriving from the next stage. The gate goes high only when both inputs are high. It goes low only when both inputs are low. Otherwise it keeps its value.

A completion detector watches the stage's own outputs. It becomes full once every pair holds a valid rail. It becomes empty again once every pair has returned to NULL. The inverse of this detector is the request the stage sends to the previous stage, where 1 asks for DATA and 0 asks for NULL.

Chaining several stages lets successive input sets occupy different stages at the same time, with a NULL wavefront between each pair of DATA wavefronts. Each gate is modelled as a state element that is re-evaluated on every edge of a free-running evaluation clock. This keeps the block synthesizable. Register outputs therefore follow their inputs after one evaluation step, and the upstream request follows the outputs after one more.

Top module: `nclRegStage`

## Requirements
- R1: A synchronous active-high `rst` drives every output rail to 0 and `reqUp` to 1 on the next clock edge.
- R2: While `reqDown` is 1, an output rail whose input rail is 1 is 1 after the next clock edge.
- R3: While `reqDown` is 1, an output rail that is 1 stays 1 even when its input rail falls to 0.
- R4: While `reqDown` is 0, an output rail whose input rail is 0 is 0 after the next clock edge.
- R5: While `reqDown` is 0, an output rail that is 0 stays 0 even when its input rail is 1.
- R6: One edge after every group at the outputs holds a valid rail (true or false), `reqUp` is 0. While any output group is NULL and `reqUp` is 1, `reqUp` stays 1.
- R7: One edge after every output group is NULL, `reqUp` is 1. While some output group is still valid and `reqUp` is 0, `reqUp` stays 0.
- R8: When the inputs never raise both rails of a group together, the outputs never raise both rails of a group together.
- R9: In a chain of stages with wire connections between them, each DATA set given to the first stage reaches the last stage's outputs intact and in order, with a NULL wavefront between consecutive sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running evaluation clock |
| rst | input | 1 | Synchronous active-high reset to NULL |
| inTrue | input | GROUPS | Incoming true rails, bit i belongs to group i |
| inFalse | input | GROUPS | Incoming false rails, bit i belongs to group i |
| reqDown | input | 1 | Request from the next stage: 1 asks for DATA, 0 asks for NULL |
| outTrue | output | GROUPS | Registered true rails |
| outFalse | output | GROUPS | Registered false rails |
| reqUp | output | 1 | Request to the previous stage: 1 asks for DATA, 0 asks for NULL |

## Verification
The bench drives a wavefront that fills only some groups. A detector that used OR instead of AND would then drop `reqUp` too early. It also drains only some groups, which exposes a detector that releases before the last group clears. It withdraws input rails while the downstream request still asks for DATA, which catches a gate without hysteresis that loses held data. It offers DATA while NULL is requested, which catches a gate that stores regardless of the request. A three-stage streaming run then checks that every word reaches the end in order with no rail pair both high. A stage whose request came from its inputs instead of its outputs would show this as lost, doubled or merged words.

// File: rtl/nclRegPkg.sv
package nclRegPkg;
  // strobes from the control half to the rail gates
  typedef struct packed {
    logic gateReq;    // request level applied to every rail gate
    logic syncClear;  // forces every rail gate to NULL
  } stageStrobeT;

  // two-input hysteresis gate: rises on both high, falls on both low
  function automatic logic hystStep(input logic a, input logic b, input logic q);
    return (a & b) | (q & (a | b));
  endfunction
endpackage

// File: rtl/nclRegDatapath.sv
module nclRegDatapath
  import nclRegPkg::*;
#(
  parameter int GROUPS = 4
) (
  input  logic              clk,
  input  stageStrobeT       strobe,
  input  logic [GROUPS-1:0] inTrue,
  input  logic [GROUPS-1:0] inFalse,
  output logic [GROUPS-1:0] outTrue,
  output logic [GROUPS-1:0] outFalse
);
  localparam int RAILS = 2 * GROUPS;

  logic [RAILS-1:0] railIn;
  logic [RAILS-1:0] railQ;

  assign railIn   = {inFalse, inTrue};
  assign outTrue  = railQ[GROUPS-1:0];
  assign outFalse = railQ[RAILS-1:GROUPS];

  for (genvar r = 0; r < RAILS; r++) begin : g_rail
    always_ff @(posedge clk) begin
      if (strobe.syncClear) railQ[r] <= 1'b0;
      else                  railQ[r] <= hystStep(railIn[r], strobe.gateReq, railQ[r]);
    end

    a_r1_rail_reset: assert property (@(posedge clk)
      strobe.syncClear |=> !railQ[r]);
    a_r2_rail_set: assert property (@(posedge clk) disable iff (strobe.syncClear)
      (strobe.gateReq && railIn[r]) |=> railQ[r]);
    a_r3_rail_hold: assert property (@(posedge clk) disable iff (strobe.syncClear)
      (strobe.gateReq && railQ[r]) |=> railQ[r]);
    a_r4_rail_clear: assert property (@(posedge clk) disable iff (strobe.syncClear)
      (!strobe.gateReq && !railIn[r]) |=> !railQ[r]);
    a_r5_rail_block: assert property (@(posedge clk) disable iff (strobe.syncClear)
      (!strobe.gateReq && !railQ[r]) |=> !railQ[r]);
  end
endmodule

// File: rtl/nclRegControl.sv
module nclRegControl
  import nclRegPkg::*;
#(
  parameter int GROUPS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqDown,
  input  logic [GROUPS-1:0] outTrue,
  input  logic [GROUPS-1:0] outFalse,
  output stageStrobeT       strobe,
  output logic              reqUp
);
  logic [GROUPS-1:0] groupValid;
  logic              allValid;
  logic              anyValid;
  logic              fullQ;

  assign groupValid = outTrue | outFalse;
  assign allValid   = &groupValid;
  assign anyValid   = |groupValid;

  // N-input completion gate with the same hysteresis rule
  always_ff @(posedge clk) begin
    if (rst) fullQ <= 1'b0;
    else     fullQ <= hystStep(allValid, allValid, fullQ) | (fullQ & anyValid);
  end

  assign strobe.gateReq   = reqDown;
  assign strobe.syncClear = rst;
  assign reqUp            = ~fullQ;

  a_r1_req_reset: assert property (@(posedge clk) rst |=> reqUp);
  a_r6_full_ack: assert property (@(posedge clk) disable iff (rst)
    allValid |=> !reqUp);
  a_r6_partial_wait: assert property (@(posedge clk) disable iff (rst)
    (reqUp && !allValid) |=> reqUp);
  a_r7_null_ack: assert property (@(posedge clk) disable iff (rst)
    !anyValid |=> reqUp);
  a_r7_partial_wait: assert property (@(posedge clk) disable iff (rst)
    (!reqUp && anyValid) |=> !reqUp);
endmodule

// File: rtl/nclRegStage.sv
module nclRegStage
  import nclRegPkg::*;
#(
  parameter int GROUPS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GROUPS-1:0] inTrue,
  input  logic [GROUPS-1:0] inFalse,
  input  logic              reqDown,
  output logic [GROUPS-1:0] outTrue,
  output logic [GROUPS-1:0] outFalse,
  output logic              reqUp
);
  stageStrobeT strobe;

  nclRegControl #(.GROUPS(GROUPS)) u_ctrl (
    .clk(clk), .rst(rst), .reqDown(reqDown),
    .outTrue(outTrue), .outFalse(outFalse),
    .strobe(strobe), .reqUp(reqUp)
  );

  nclRegDatapath #(.GROUPS(GROUPS)) u_data (
    .clk(clk), .strobe(strobe),
    .inTrue(inTrue), .inFalse(inFalse),
    .outTrue(outTrue), .outFalse(outFalse)
  );
endmodule

// File: tb/nclRegStage_test.sv
`timescale 1ns/1ps
module nclRegStage_test;
  localparam int G = 4;
  localparam int WORDS = 24;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic         rst = 1'b1;
  logic [G-1:0] srcT = '0, srcF = '0;
  logic         tbReq = 1'b0;
  logic         chainMode = 1'b0;
  logic         sinkReq = 1'b1;

  logic [G-1:0] t0, f0, t1, f1, t2, f2;
  logic         up0, up1, up2, down0;

  int checks = 0, fails = 0;
  logic [G-1:0] expQ[$];
  int received = 0;

  assign down0 = chainMode ? up1 : tbReq;

  nclRegStage #(.GROUPS(G)) uut (
    .clk(clk), .rst(rst), .inTrue(srcT), .inFalse(srcF), .reqDown(down0),
    .outTrue(t0), .outFalse(f0), .reqUp(up0));
  nclRegStage #(.GROUPS(G)) midStage (
    .clk(clk), .rst(rst), .inTrue(t0), .inFalse(f0), .reqDown(up2),
    .outTrue(t1), .outFalse(f1), .reqUp(up1));
  nclRegStage #(.GROUPS(G)) lastStage (
    .clk(clk), .rst(rst), .inTrue(t1), .inFalse(f1), .reqDown(sinkReq),
    .outTrue(t2), .outFalse(f2), .reqUp(up2));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic checkOut(input string req, input logic [G-1:0] eT, input logic [G-1:0] eF);
    check({t0, f0} == {eT, eF}, req, {t0, f0}, {eT, eF});
  endtask

  // driver: offers words to the first stage following its request
  task automatic streamDriver();
    logic isNull = 1'b1;
    int sent = 0;
    while (received < WORDS) begin
      @(negedge clk);
      if (isNull && up0 && sent < WORDS) begin
        logic [G-1:0] w = G'((sent * 7 + 3) ^ (sent >> 1));
        expQ.push_back(w);
        srcT = w; srcF = ~w; isNull = 1'b0; sent++;
      end else if (!isNull && !up0) begin
        srcT = '0; srcF = '0; isNull = 1'b1;
      end
    end
  endtask

  // monitor: pops expected words as the last stage completes them
  task automatic streamMonitor();
    while (received < WORDS) begin
      @(negedge clk);
      if (sinkReq && ((t2 | f2) == '1)) begin
        logic [G-1:0] e = expQ.pop_front();
        check(t2 == e && f2 == ~e, "R9", {t2, f2}, {e, ~e});
        check(((t0 & f0) | (t1 & f1) | (t2 & f2)) == '0, "R8",
              {(t0 & f0), (t1 & f1), (t2 & f2)}, '0);
        sinkReq = 1'b0;
        received++;
      end else if (!sinkReq && ((t2 | f2) == '0)) begin
        sinkReq = 1'b1;   // NULL wavefront seen between words (R9)
      end
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", received, WORDS);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); tick();
    checkOut("R1", '0, '0);
    check(up0 == 1'b1, "R1", up0, 1);
    rst = 1'b0;

    tbReq = 1'b1; srcT = 4'b0001; srcF = '0;
    tick(); checkOut("R2", 4'b0001, '0);
    tick(); check(up0 == 1'b1, "R6 partial", up0, 1);

    srcT = 4'b0101; srcF = 4'b1010;
    tick(); checkOut("R2", 4'b0101, 4'b1010);
    check(up0 == 1'b1, "R6 latency", up0, 1);
    tick(); check(up0 == 1'b0, "R6", up0, 0);

    srcT = '0; srcF = '0;
    tick(); tick(); checkOut("R3", 4'b0101, 4'b1010);
    check(up0 == 1'b0, "R3", up0, 0);

    tbReq = 1'b0; srcT = 4'b0100; srcF = 4'b1010;
    tick(); checkOut("R4 partial", 4'b0100, 4'b1010);
    tick(); check(up0 == 1'b0, "R7 partial", up0, 0);

    srcT = '0; srcF = '0;
    tick(); checkOut("R4", '0, '0);
    tick(); check(up0 == 1'b1, "R7", up0, 1);

    srcT = 4'b1111; srcF = '0;
    tick(); tick(); checkOut("R5", '0, '0);
    srcT = '0; srcF = 4'b1111;
    tick(); checkOut("R5", '0, '0);

    tbReq = 1'b1; srcT = 4'b0011; srcF = 4'b1100;
    tick(); tick(); checkOut("R2", 4'b0011, 4'b1100);
    rst = 1'b1;
    tick(); checkOut("R1", '0, '0);
    check(up0 == 1'b1, "R1", up0, 1);

    srcT = '0; srcF = '0; chainMode = 1'b1;
    tick(); rst = 1'b0;
    fork
      streamDriver();
      streamMonitor();
    join
    check(received == WORDS, "R9 count", received, WORDS);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule